// File: doc/BRIEF.md
# System Configuration Register Block

This block is a small memory-mapped register file behind a 32-bit slave port that decodes a 4 KB window. It holds the general configuration registers of a board-level system. One control register drives a remap line, and another drives a row of LED outputs. A switch register reflects an input port. Three read-only words report board and image identity. A clock-lock status word combines per-loop lock inputs under a mask that software writes.

The 12-bit board variant code sits in bits [15:4] of the identity word. It decides at elaboration whether three auxiliary registers exist. A gated-off register behaves exactly like an unmapped offset.

The port uses a single-cycle write strobe and a single-cycle read strobe. Read data is registered and appears one cycle after the read strobe. The port is always ready.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset the registers hold these values: control word (offset 0x000) = CTL0_RST, LED word (0x004) = 0, aux words (0x008, 0x014, 0x018) = 0, lock mask = 0xFF. The read data output is 0. With all lock inputs high, the lock word (0x100) reads 0xFFFF0001.
- R2: The control word at 0x000 and the LED word at 0x004 store full 32-bit writes. A read strobe presents the addressed value on rdata_o one cycle later, and rdata_o holds between reads. A read and a write to the same offset in the same cycle return the old value. ready_o is always 1.
- R3: remap_o equals bit 0 of the control word, starting from the cycle after a write.
- R4: led_o[i] equals bit i of the LED word, for each of the NUM_LEDS outputs.
- R5: The aux words at 0x008 and 0x014 exist only when the variant code (ID bits [15:4]) is 0x524 or 0x547. Otherwise they read 0 and writes to them are ignored.
- R6: The aux word at 0x018 exists only when the variant code is 0x524. Otherwise it reads 0 and writes to it are ignored.
- R7: Offset 0x00C reads the switch input on bits [7:0] and zero above. Writes to it are ignored.
- R8: Offsets 0x010, 0xFF8 and 0xFFC read the values INFO4_VAL, AID_VAL and ID_VAL. Writes to them are ignored.
- R9: The lock word at 0x100 is laid out as follows. Bits [31:24] are a writable mask. Bits [23:16] show the lock inputs at the time of the read. Bits [15:1] are zero. Bit 0 is 1 exactly when every lock input whose mask bit is set is high. Writes to bits [23:0] have no effect.
- R10: Offsets outside the map, and offsets that are not word aligned, read 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ready_o | output | 1 | Always high |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LEDS | LED drive |
| sw_i | input | SW_W | Switch inputs |
| lock_i | input | LOCK_W | Per-loop lock inputs |

## Verification
A corrupted bit 0 of the control word, or a corrupted low LED bit, reaches remap_o or led_o in the cycle after the bad write. Other stored state stays hidden until it is read, and then shows on rdata_o one cycle after the read strobe. For this reason, the bench reads back every writable word after each group of writes. It also reads back every writable word after writes to gated, read-only and unmapped offsets. A wrong gating decision shows up as data that should read zero but does not, or as zero where data was expected. To catch this, the bench runs three instances whose variant codes differ. A fault in the lock summary shows only in bit 0 of a lock-word read, so several mask and lock patterns are read.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // byte offsets decoded by the block
  localparam logic [ADDR_W-1:0] OFF_CTL0  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_LED   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_AUX2  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SW    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_INFO4 = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_AUX5  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_AUX6  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_AID   = 12'hFF8;
  localparam logic [ADDR_W-1:0] OFF_ID    = 12'hFFC;

  localparam logic [11:0] VAR_FULL = 12'h524;
  localparam logic [11:0] VAR_PART = 12'h547;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTL0,
    SEL_LED,
    SEL_AUX2,
    SEL_SW,
    SEL_INFO4,
    SEL_AUX5,
    SEL_AUX6,
    SEL_LOCK,
    SEL_AID,
    SEL_ID
  } reg_sel_e;

  function automatic logic [11:0] variant_code(input logic [DATA_W-1:0] id_word);
    return id_word[15:4];
  endfunction

endpackage

// File: rtl/scfg_addr_decode.sv
module scfg_addr_decode
  import sys_cfg_pkg::*;
#(
  parameter bit HAS_AUX25 = 1'b1,
  parameter bit HAS_AUX6  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    case (addr_i)
      OFF_CTL0:  sel_o = SEL_CTL0;
      OFF_LED:   sel_o = SEL_LED;
      OFF_AUX2:  sel_o = HAS_AUX25 ? SEL_AUX2 : SEL_NONE;
      OFF_SW:    sel_o = SEL_SW;
      OFF_INFO4: sel_o = SEL_INFO4;
      OFF_AUX5:  sel_o = HAS_AUX25 ? SEL_AUX5 : SEL_NONE;
      OFF_AUX6:  sel_o = HAS_AUX6 ? SEL_AUX6 : SEL_NONE;
      OFF_LOCK:  sel_o = SEL_LOCK;
      OFF_AID:   sel_o = SEL_AID;
      OFF_ID:    sel_o = SEL_ID;
      default:   sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/scfg_reg_store.sv
module scfg_reg_store
  import sys_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTL0_RST  = '0,
  parameter bit                HAS_AUX25 = 1'b1,
  parameter bit                HAS_AUX6  = 1'b1,
  parameter int unsigned       MASK_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl0_o,
  output logic [DATA_W-1:0] led_word_o,
  output logic [DATA_W-1:0] aux2_o,
  output logic [DATA_W-1:0] aux5_o,
  output logic [DATA_W-1:0] aux6_o,
  output logic [MASK_W-1:0] lock_mask_o
);

  localparam int unsigned MASK_LSB = DATA_W - MASK_W;

  logic ctl0_en, led_en, aux2_en, aux5_en, aux6_en, mask_en;

  // write enables, one per stored word
  always_comb begin
    ctl0_en = wr_en_i && (sel_i == SEL_CTL0);
    led_en  = wr_en_i && (sel_i == SEL_LED);
    aux2_en = wr_en_i && (sel_i == SEL_AUX2);
    aux5_en = wr_en_i && (sel_i == SEL_AUX5);
    aux6_en = wr_en_i && (sel_i == SEL_AUX6);
    mask_en = wr_en_i && (sel_i == SEL_LOCK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl0_o <= CTL0_RST;
    else if (ctl0_en) ctl0_o <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_word_o <= '0;
    else if (led_en) led_word_o <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_mask_o <= '1;
    else if (mask_en) lock_mask_o <= wdata_i[DATA_W-1:MASK_LSB];
  end

  generate
    if (HAS_AUX25) begin : g_aux25
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       aux2_o <= '0;
        else if (aux2_en) aux2_o <= wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       aux5_o <= '0;
        else if (aux5_en) aux5_o <= wdata_i;
      end
    end else begin : g_no_aux25
      assign aux2_o = '0;
      assign aux5_o = '0;
    end

    if (HAS_AUX6) begin : g_aux6
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       aux6_o <= '0;
        else if (aux6_en) aux6_o <= wdata_i;
      end
    end else begin : g_no_aux6
      assign aux6_o = '0;
    end
  endgenerate

  // R9: mask takes the top field of the written word
  p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == SEL_LOCK) |=> (lock_mask_o == $past(wdata_i[DATA_W-1:MASK_LSB])));

  // R10: a write that decodes nowhere leaves the control word alone
  p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == SEL_NONE) |=> $stable(ctl0_o));

endmodule

// File: rtl/scfg_lock_status.sv
module scfg_lock_status
  import sys_cfg_pkg::*;
#(
  parameter int unsigned LOCK_W = 8
) (
  input  logic [LOCK_W-1:0] mask_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic [DATA_W-1:0] word_o
);

  localparam int unsigned MASK_MSB = DATA_W - 1;
  localparam int unsigned LOCK_MSB = DATA_W - 1 - LOCK_W;

  logic all_locked;

  always_comb begin
    all_locked = &(lock_i | ~mask_i);
    word_o                      = '0;
    word_o[MASK_MSB -: LOCK_W]  = mask_i;
    word_o[LOCK_MSB -: LOCK_W]  = lock_i;
    word_o[0]                   = all_locked;
  end

endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
  import sys_cfg_pkg::*;
#(
  parameter logic [31:0] CTL0_RST  = 32'h0000_0001,
  parameter logic [31:0] INFO4_VAL = 32'h0000_0003,
  parameter logic [31:0] AID_VAL   = 32'h0220_0000,
  parameter logic [31:0] ID_VAL    = 32'h4105_5240,
  parameter int unsigned NUM_LEDS  = 8,
  parameter int unsigned SW_W      = 8,
  parameter int unsigned LOCK_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [11:0]         addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                ready_o,
  output logic                remap_o,
  output logic [NUM_LEDS-1:0] led_o,
  input  logic [SW_W-1:0]     sw_i,
  input  logic [LOCK_W-1:0]   lock_i
);

  localparam logic [11:0] VARIANT   = variant_code(ID_VAL);
  localparam bit          HAS_AUX25 = (VARIANT == VAR_FULL) || (VARIANT == VAR_PART);
  localparam bit          HAS_AUX6  = (VARIANT == VAR_FULL);

  reg_sel_e          sel;
  logic [DATA_W-1:0] ctl0_w, led_w, aux2_w, aux5_w, aux6_w, lock_word_w;
  logic [LOCK_W-1:0] mask_w;
  logic [DATA_W-1:0] rdata_d;

  scfg_addr_decode #(
    .HAS_AUX25 (HAS_AUX25),
    .HAS_AUX6  (HAS_AUX6)
  ) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  scfg_reg_store #(
    .CTL0_RST  (CTL0_RST),
    .HAS_AUX25 (HAS_AUX25),
    .HAS_AUX6  (HAS_AUX6),
    .MASK_W    (LOCK_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .ctl0_o      (ctl0_w),
    .led_word_o  (led_w),
    .aux2_o      (aux2_w),
    .aux5_o      (aux5_w),
    .aux6_o      (aux6_w),
    .lock_mask_o (mask_w)
  );

  scfg_lock_status #(
    .LOCK_W (LOCK_W)
  ) u_lock (
    .mask_i (mask_w),
    .lock_i (lock_i),
    .word_o (lock_word_w)
  );

  // read mux, next state of the read data register
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_CTL0:  rdata_d = ctl0_w;
      SEL_LED:   rdata_d = led_w;
      SEL_AUX2:  rdata_d = aux2_w;
      SEL_SW:    rdata_d = {{(DATA_W-SW_W){1'b0}}, sw_i};
      SEL_INFO4: rdata_d = INFO4_VAL;
      SEL_AUX5:  rdata_d = aux5_w;
      SEL_AUX6:  rdata_d = aux6_w;
      SEL_LOCK:  rdata_d = lock_word_w;
      SEL_AID:   rdata_d = AID_VAL;
      SEL_ID:    rdata_d = ID_VAL;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end

  assign ready_o = 1'b1;
  assign remap_o = ctl0_w[0];

  generate
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      assign led_o[i] = led_w[i];
    end
  endgenerate

  // R2: read data holds between read strobes
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

  // R3: remap line follows the written bit
  p_remap_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFF_CTL0) |=> (remap_o == $past(wdata_i[0])));

  // R4: LED outputs follow the written low bits
  p_led_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFF_LED) |=> (led_o == $past(wdata_i[NUM_LEDS-1:0])));

  // R5: gated aux words read zero
  p_aux25_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !HAS_AUX25 && (addr_i == OFF_AUX2 || addr_i == OFF_AUX5)) |=> (rdata_o == '0));

  // R6: gated aux6 word reads zero
  p_aux6_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !HAS_AUX6 && addr_i == OFF_AUX6) |=> (rdata_o == '0));

  // R7: switch word reflects the inputs at the read
  p_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == OFF_SW) |=> (rdata_o == {{(DATA_W-SW_W){1'b0}}, $past(sw_i)}));

  // R8: identity word is constant
  p_id_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == OFF_ID) |=> (rdata_o == ID_VAL));

  // R9: summary bit agrees with the returned mask and lock inputs
  p_lock_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == OFF_LOCK) |=>
      (rdata_o[0] == &($past(lock_i) | ~rdata_o[DATA_W-1 -: LOCK_W])));

  // R10: undecoded offsets read zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && sel == SEL_NONE) |=> (rdata_o == '0));

endmodule

// File: tb/sys_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module sys_cfg_regs_tb_top;

  localparam logic [31:0] C0_RST = 32'h0000_0001;
  localparam logic [31:0] INFO4  = 32'h0000_0003;
  localparam logic [31:0] AIDV   = 32'h0220_0000;
  localparam logic [31:0] ID_A   = 32'h4105_5240;  // code 0x524
  localparam logic [31:0] ID_B   = 32'h4104_5470;  // code 0x547
  localparam logic [31:0] ID_C   = 32'h4104_5110;  // code 0x511

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [7:0]  sw, lock;

  logic [31:0] rd_a, rd_b, rd_c;
  logic        rdy_a, rdy_b, rdy_c;
  logic        rm_a, rm_b, rm_c;
  logic [7:0]  led_a, led_b, led_c;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sys_cfg_regs #(.CTL0_RST(C0_RST), .INFO4_VAL(INFO4), .AID_VAL(AIDV), .ID_VAL(ID_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_a), .ready_o(rdy_a), .remap_o(rm_a), .led_o(led_a),
    .sw_i(sw), .lock_i(lock));

  sys_cfg_regs #(.CTL0_RST(C0_RST), .INFO4_VAL(INFO4), .AID_VAL(AIDV), .ID_VAL(ID_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_b), .ready_o(rdy_b), .remap_o(rm_b), .led_o(led_b),
    .sw_i(sw), .lock_i(lock));

  sys_cfg_regs #(.CTL0_RST(C0_RST), .INFO4_VAL(INFO4), .AID_VAL(AIDV), .ID_VAL(ID_C)) dut_c (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_c), .ready_o(rdy_c), .remap_o(rm_c), .led_o(led_c),
    .sw_i(sw), .lock_i(lock));

  // behavioural reference state, one entry per instance
  logic [31:0] m_ctl0 [3];
  logic [31:0] m_led  [3];
  logic [31:0] m_a2   [3];
  logic [31:0] m_a5   [3];
  logic [31:0] m_a6   [3];
  logic [31:0] m_rd   [3];
  logic [7:0]  m_mask [3];

  function automatic logic [31:0] id_of(int v);
    if (v == 0) return ID_A;
    if (v == 1) return ID_B;
    return ID_C;
  endfunction

  function automatic bit has25(int v);
    logic [31:0] idw;
    idw = id_of(v);
    return (idw[15:4] == 12'h524) || (idw[15:4] == 12'h547);
  endfunction

  function automatic bit has6(int v);
    logic [31:0] idw;
    idw = id_of(v);
    return idw[15:4] == 12'h524;
  endfunction

  function automatic logic [31:0] model_read(int v, logic [11:0] a);
    logic [31:0] r;
    r = 32'h0;
    case (a)
      12'h000: r = m_ctl0[v];
      12'h004: r = m_led[v];
      12'h008: r = has25(v) ? m_a2[v] : 32'h0;
      12'h00C: r = {24'h0, sw};
      12'h010: r = INFO4;
      12'h014: r = has25(v) ? m_a5[v] : 32'h0;
      12'h018: r = has6(v) ? m_a6[v] : 32'h0;
      12'h100: begin
        r = {m_mask[v], lock, 16'h0};
        r[0] = 1'b1;
        for (int k = 0; k < 8; k++)
          if (m_mask[v][k] && !lock[k]) r[0] = 1'b0;
      end
      12'hFF8: r = AIDV;
      12'hFFC: r = id_of(v);
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  task automatic model_write(int v, logic [11:0] a, logic [31:0] d);
    case (a)
      12'h000: m_ctl0[v] = d;
      12'h004: m_led[v]  = d;
      12'h008: if (has25(v)) m_a2[v] = d;
      12'h014: if (has25(v)) m_a5[v] = d;
      12'h018: if (has6(v))  m_a6[v] = d;
      12'h100: m_mask[v] = d[31:24];
      default: ;
    endcase
  endtask

  task automatic chk(string req, int v, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst%0d %s actual=%h expected=%h", req, v, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, 0, "rdata", rd_a, m_rd[0]);
    chk(req, 1, "rdata", rd_b, m_rd[1]);
    chk(req, 2, "rdata", rd_c, m_rd[2]);
    chk(req, 0, "remap", {31'h0, rm_a}, {31'h0, m_ctl0[0][0]});
    chk(req, 1, "remap", {31'h0, rm_b}, {31'h0, m_ctl0[1][0]});
    chk(req, 2, "remap", {31'h0, rm_c}, {31'h0, m_ctl0[2][0]});
    chk(req, 0, "led", {24'h0, led_a}, {24'h0, m_led[0][7:0]});
    chk(req, 1, "led", {24'h0, led_b}, {24'h0, m_led[1][7:0]});
    chk(req, 2, "led", {24'h0, led_c}, {24'h0, m_led[2][7:0]});
    chk("R2", 0, "ready", {31'h0, rdy_a & rdy_b & rdy_c}, 32'h1);
  endtask

  // one bus cycle: drive, advance the model, check just after the edge
  task automatic step(bit w, bit r, logic [11:0] a, logic [31:0] d, string req);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    for (int v = 0; v < 3; v++) begin
      if (r) m_rd[v] = model_read(v, a);
      if (w) model_write(v, a, d);
    end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    compare_all(req);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string req);
    step(1'b1, 1'b0, a, d, req);
  endtask

  task automatic rd(logic [11:0] a, string req);
    step(1'b0, 1'b1, a, 32'h0, req);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    sw = 8'h00; lock = 8'hFF;
    for (int v = 0; v < 3; v++) begin
      m_ctl0[v] = C0_RST; m_led[v] = 0; m_a2[v] = 0; m_a5[v] = 0; m_a6[v] = 0;
      m_rd[v] = 0; m_mask[v] = 8'hFF;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare_all("R1");
    // R1: reset contents of every mapped word
    rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h008, "R1"); rd(12'h014, "R1");
    rd(12'h018, "R1"); rd(12'h100, "R1");

    // R2: read/write patterns and same-cycle read of old value
    wr(12'h000, 32'hA5A5_5A5A, "R2"); rd(12'h000, "R2");
    wr(12'h000, 32'hFFFF_FFFE, "R2"); rd(12'h000, "R2");
    step(1'b1, 1'b1, 12'h000, 32'h1234_5671, "R2"); rd(12'h000, "R2");
    step(1'b0, 1'b0, 12'h000, 32'h0, "R2");

    // R3: remap line
    wr(12'h000, 32'h0, "R3"); wr(12'h000, 32'h8000_0001, "R3"); wr(12'h000, 32'h2, "R3");

    // R4: LED drive
    wr(12'h004, 32'h0000_0080, "R4"); wr(12'h004, 32'h0000_005A, "R4");
    wr(12'h004, 32'hFFFF_FF00, "R4"); rd(12'h004, "R4");

    // R5 / R6: variant-gated aux words
    wr(12'h008, 32'hCAFE_0002, "R5"); rd(12'h008, "R5");
    wr(12'h014, 32'h0BAD_F00D, "R5"); rd(12'h014, "R5");
    wr(12'h018, 32'h1357_9BDF, "R6"); rd(12'h018, "R6");

    // R7: switches
    sw = 8'h3C; rd(12'h00C, "R7");
    wr(12'h00C, 32'hFFFF_FFFF, "R7");
    sw = 8'hC3; rd(12'h00C, "R7");

    // R8: read-only identity words
    wr(12'h010, 32'h0, "R8"); wr(12'hFF8, 32'h0, "R8"); wr(12'hFFC, 32'h0, "R8");
    rd(12'h010, "R8"); rd(12'hFF8, "R8"); rd(12'hFFC, "R8");

    // R9: lock word
    wr(12'h100, 32'h0F00_FFFF, "R9");
    lock = 8'hFF; rd(12'h100, "R9");
    lock = 8'hF7; rd(12'h100, "R9");
    lock = 8'hF0; rd(12'h100, "R9");
    lock = 8'h0F; rd(12'h100, "R9");
    wr(12'h100, 32'h0000_0000, "R9");
    lock = 8'h00; rd(12'h100, "R9");
    wr(12'h100, 32'h8000_0000, "R9");
    lock = 8'h7F; rd(12'h100, "R9");
    lock = 8'hFF; rd(12'h100, "R9");

    // R10: unmapped and misaligned offsets
    wr(12'h01C, 32'hFFFF_FFFF, "R10"); wr(12'h0A0, 32'hFFFF_FFFF, "R10");
    wr(12'h104, 32'hFFFF_FFFF, "R10"); wr(12'h002, 32'hFFFF_FFFF, "R10");
    wr(12'h005, 32'hFFFF_FFFF, "R10"); wr(12'hFF4, 32'hFFFF_FFFF, "R10");
    rd(12'h01C, "R10"); rd(12'h0A0, "R10"); rd(12'h104, "R10");
    rd(12'h002, "R10"); rd(12'hFF4, "R10");
    rd(12'h000, "R10"); rd(12'h004, "R10"); rd(12'h008, "R10");
    rd(12'h014, "R10"); rd(12'h018, "R10"); rd(12'h100, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule